// File: doc/BRIEF.md
# Zero-Power Memory Access Controller

This block wraps a small register-based RAM. The array sits in standby, with its enable low, whenever the host is not accessing it. When the host presents a new read address, or issues a write, the controller opens a short active window of a configurable number of clock cycles. During that window the array is enabled and the operation runs. The read result is captured into an output latch. The controller then returns to standby, and the latched word stays on the read-data port until a later access changes it.

The array holds a fixed number of bits. A static width input selects how the host sees it: either as a byte-wide array with twice the depth, or as a 16-bit-wide array. A backup-hold input blocks all access while the supply is at its backup level, so the array contents and the latch are kept unchanged. A standby output lets a host or a bench count the active cycles of each access.

Top module: `lowpwr_mem_ctrl`

## Requirements
- R1: After reset, arrayEn is 0, standby is 1 and rdData is 0. With no request, the array stays in standby.
- R2: A read request opens a window in which arrayEn is high for exactly ACTIVE_CYCLES cycles. A read request is sel=1 and wrEn=0, sampled at a clock edge, with either sel low at the previous edge or an effective address different from the previous edge. The window starts in the cycle after the edge that sampled the request.
- R3: New read data appears on rdData at the clock edge that closes the window. After that, rdData is held unchanged through standby.
- R4: When wideMode=1, the array is 1K x 16. The word index is addr[9:0], addr[10] is ignored, and rdData carries the whole word.
- R5: When wideMode=0, the array is 2K x 8. Byte address b lives in word b>>1, with addr[0]=1 selecting bits 15:8. rdData[7:0] carries the byte and rdData[15:8] is 0.
- R6: A write request (sel=1 and wrEn=1 at an edge) opens a window of ACTIVE_CYCLES cycles, and the write is committed when the window closes. In byte mode, only the addressed byte lane is changed, using wrData[7:0].
- R7: A write changes rdData only when its effective address equals the address of the last read held in the latch. In that case rdData takes the written value.
- R8: A request sampled while a window is open restarts the window, and the earlier pending operation is dropped. arrayEn then stays high for ACTIVE_CYCLES cycles after the restarting edge.
- R9: While backupHold is 1, arrayEn stays 0, requests are discarded, and both the array and rdData keep their contents. An open window is closed at once, without performing its operation.
- R10: standby is always the inverse of arrayEn.
- R11: If sel stays high on the same effective address, no further window opens after the first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wideMode | input | 1 | Static organisation: 1 = 16-bit words, 0 = bytes |
| backupHold | input | 1 | Supply at backup level; blocks every access |
| sel | input | 1 | Chip select |
| wrEn | input | 1 | Write strobe, qualified by sel |
| addr | input | 11 | Byte address (byte mode) or word address in bits 9:0 (wide mode) |
| wrData | input | 16 | Write data; bits 7:0 only in byte mode |
| rdData | output | 16 | Latched read data |
| arrayEn | output | 1 | Array enable, high only during an active window |
| standby | output | 1 | High while the array is in standby |

## Verification
A wrong window counter shows as a run of arrayEn that is too long or too short in every access, and it is visible within ACTIVE_CYCLES+1 cycles of the request. A stale change-detection register shows up in two ways: a missing window on a new address, or an extra window while the address is held. A wrong lane or index mapping shows as wrong rdData at the edge that closes the window. Sweeping every word in wide mode and every byte in byte mode exposes such a mapping error on the first affected location.

// File: rtl/lpmem_pkg.sv
package lpmem_pkg;
  localparam int BYTE_W = 8;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadReq;  // capture address / data / direction of a new request
    logic isWrite;  // direction of the request being captured
    logic exec;     // window closes this edge: perform the pending operation
  } lpCmd_t;
endpackage

// File: rtl/lpmem_array.sv
module lpmem_array #(
  parameter int WORD_W  = 16,
  parameter int WORDS   = 1024,
  parameter int WORD_AW = 10
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [WORD_W/8-1:0]       laneEn,
  input  logic [WORD_AW-1:0]        idx,
  input  logic [WORD_W-1:0]         wdata,
  output logic [WORD_W-1:0]         rword
);
  localparam int LANES = WORD_W / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] laneMem [WORDS];
    always_ff @(posedge clk) begin
      if (we && laneEn[l]) laneMem[idx] <= wdata[l*8 +: 8];
    end
    assign rword[l*8 +: 8] = laneMem[idx];
  end
endmodule

// File: rtl/lpmem_ctrl.sv
module lpmem_ctrl
  import lpmem_pkg::*;
#(
  parameter int WORD_AW       = 10,
  parameter int LANE_BITS     = 1,
  parameter int ACTIVE_CYCLES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel,
  input  logic                         wrEn,
  input  logic                         wideMode,
  input  logic                         backupHold,
  input  logic [WORD_AW+LANE_BITS-1:0] addr,
  output lpCmd_t                       cmd,
  output logic                         arrayEn,
  output logic                         standby
);
  localparam int BYTE_AW = WORD_AW + LANE_BITS;
  localparam int CNT_W   = $clog2(ACTIVE_CYCLES + 1);

  logic [BYTE_AW-1:0] addrKey, lastKey;
  logic               lastSel;
  logic               readReq, writeReq, startReq;
  logic               active;
  logic [CNT_W-1:0]   cnt;

  // Effective address: wide mode ignores the lane bits above the word index.
  assign addrKey  = wideMode ? {{LANE_BITS{1'b0}}, addr[WORD_AW-1:0]} : addr;
  assign readReq  = sel && !wrEn && (!lastSel || (addrKey != lastKey));
  assign writeReq = sel && wrEn;
  assign startReq = !backupHold && (readReq || writeReq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastKey <= '0;
      lastSel <= 1'b0;
    end else begin
      lastKey <= addrKey;
      lastSel <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (backupHold) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (startReq) begin
      active <= 1'b1;
      cnt    <= CNT_W'(ACTIVE_CYCLES - 1);
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  always_comb begin
    cmd.loadReq = startReq;
    cmd.isWrite = writeReq;
    cmd.exec    = active && (cnt == '0) && !startReq && !backupHold;
  end

  assign arrayEn = active;
  assign standby = !active;

  // R9
  backup_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backupHold |=> !arrayEn);
  // R2
  request_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startReq |=> arrayEn);
  // R1
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arrayEn && !(sel && !backupHold)) |=> !arrayEn);
endmodule

// File: rtl/lpmem_dp.sv
module lpmem_dp
  import lpmem_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int WORD_AW   = 10,
  parameter int LANE_BITS = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  lpCmd_t                       cmd,
  input  logic                         wideMode,
  input  logic [WORD_AW+LANE_BITS-1:0] addr,
  input  logic [WORD_W-1:0]            wrData,
  input  logic [WORD_W-1:0]            arrRword,
  output logic                         arrWe,
  output logic [WORD_W/8-1:0]          arrLaneEn,
  output logic [WORD_AW-1:0]           arrIdx,
  output logic [WORD_W-1:0]            arrWdata,
  output logic [WORD_W-1:0]            rdData
);
  localparam int BYTE_AW = WORD_AW + LANE_BITS;
  localparam int LANES   = WORD_W / 8;

  logic [BYTE_AW-1:0]   reqAddr, reqKey, latchKey;
  logic                 reqWr;
  logic [WORD_W-1:0]    reqData;
  logic [LANE_BITS-1:0] reqLane;
  logic [WORD_W-1:0]    readView, writeView, rdLatch;
  logic                 latchValid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqAddr <= '0;
      reqWr   <= 1'b0;
      reqData <= '0;
    end else if (cmd.loadReq) begin
      reqAddr <= addr;
      reqWr   <= cmd.isWrite;
      reqData <= wrData;
    end
  end

  assign reqKey    = wideMode ? {{LANE_BITS{1'b0}}, reqAddr[WORD_AW-1:0]} : reqAddr;
  assign reqLane   = reqAddr[LANE_BITS-1:0];
  assign arrIdx    = wideMode ? reqAddr[WORD_AW-1:0] : reqAddr[BYTE_AW-1:LANE_BITS];
  assign arrWe     = cmd.exec && reqWr;
  assign arrLaneEn = wideMode ? {LANES{1'b1}} : (LANES'(1) << reqLane);
  assign arrWdata  = wideMode ? reqData : {LANES{reqData[7:0]}};
  assign readView  = wideMode ? arrRword : WORD_W'(arrRword[reqLane*8 +: 8]);
  assign writeView = wideMode ? reqData : WORD_W'(reqData[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdLatch    <= '0;
      latchKey   <= '0;
      latchValid <= 1'b0;
    end else if (cmd.exec && !reqWr) begin
      rdLatch    <= readView;
      latchKey   <= reqKey;
      latchValid <= 1'b1;
    end else if (cmd.exec && reqWr && latchValid && (reqKey == latchKey)) begin
      rdLatch <= writeView;
    end
  end

  assign rdData = rdLatch;

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.exec |=> $stable(rdData));
  // R7
  write_miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.exec && reqWr && (reqKey != latchKey)) |=> $stable(rdData));
endmodule

// File: rtl/lowpwr_mem_ctrl.sv
module lowpwr_mem_ctrl
  import lpmem_pkg::*;
#(
  parameter int RAM_BITS      = 16384,
  parameter int WORD_W        = 16,
  parameter int ACTIVE_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wideMode,
  input  logic        backupHold,
  input  logic        sel,
  input  logic        wrEn,
  input  logic [10:0] addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        arrayEn,
  output logic        standby
);
  localparam int LANES     = WORD_W / BYTE_W;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int WORDS     = RAM_BITS / WORD_W;
  localparam int WORD_AW   = $clog2(WORDS);

  lpCmd_t              cmd;
  logic                arrWe;
  logic [LANES-1:0]    arrLaneEn;
  logic [WORD_AW-1:0]  arrIdx;
  logic [WORD_W-1:0]   arrWdata, arrRword;

  lpmem_ctrl #(.WORD_AW(WORD_AW), .LANE_BITS(LANE_BITS), .ACTIVE_CYCLES(ACTIVE_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wrEn(wrEn), .wideMode(wideMode),
    .backupHold(backupHold), .addr(addr), .cmd(cmd), .arrayEn(arrayEn), .standby(standby)
  );

  lpmem_dp #(.WORD_W(WORD_W), .WORD_AW(WORD_AW), .LANE_BITS(LANE_BITS)) dp_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wideMode(wideMode), .addr(addr), .wrData(wrData),
    .arrRword(arrRword), .arrWe(arrWe), .arrLaneEn(arrLaneEn), .arrIdx(arrIdx),
    .arrWdata(arrWdata), .rdData(rdData)
  );

  lpmem_array #(.WORD_W(WORD_W), .WORDS(WORDS), .WORD_AW(WORD_AW)) array_i (
    .clk(clk), .we(arrWe), .laneEn(arrLaneEn), .idx(arrIdx), .wdata(arrWdata), .rword(arrRword)
  );
endmodule

// File: tb/lowpwr_mem_ctrl_tb.sv
module lowpwr_mem_ctrl_tb_top;
  localparam int ACT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wideMode = 1'b1;
  logic        backupHold = 1'b0;
  logic        sel = 1'b0;
  logic        wrEn = 1'b0;
  logic [10:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        arrayEn, standby;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] model [1024];

  lowpwr_mem_ctrl #(.ACTIVE_CYCLES(ACT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wideMode(wideMode), .backupHold(backupHold), .sel(sel),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .arrayEn(arrayEn), .standby(standby)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R10: standby mirrors arrayEn at every sample point
  always @(negedge clk) if (rst_n) check(standby == !arrayEn, "R10 standby", standby, !arrayEn);

  function automatic logic [15:0] wpat(input int i);
    return 16'(i * 40503 + 4660);
  endfunction

  // One access: request held for one edge, then deselected; window length checked.
  task automatic access(input bit wr, input logic [10:0] a, input logic [15:0] d, input string tag);
    int n;
    sel = 1'b1; wrEn = wr; addr = a; wrData = d;
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0;
    n = 0;
    while (arrayEn && n < 20) begin n++; @(negedge clk); end
    check(n == ACT, tag, n, ACT);
  endtask

  logic [15:0] expv;
  logic [15:0] hold;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(arrayEn == 1'b0, "R1 arrayEn", arrayEn, 0);
    check(standby == 1'b1, "R1 standby", standby, 1);
    check(rdData == 16'h0, "R1 rdData", rdData, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(arrayEn == 1'b0, "R1 idle", arrayEn, 0);

    // R4/R6: wide writes of every word, then wide reads with addr[10] toggled
    wideMode = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      model[i] = wpat(i);
      access(1'b1, 11'(i), wpat(i), "R6 write window");
    end
    for (int i = 0; i < 1024; i++) begin
      access(1'b0, {1'(i & 1), 10'(i)}, 16'h0, "R2 read window");
      check(rdData == model[i], "R4 wide read", rdData, model[i]);
    end

    // R5: byte reads of every byte
    wideMode = 1'b0;
    for (int b = 0; b < 2048; b++) begin
      access(1'b0, 11'(b), 16'h0, "R2 byte window");
      expv = {8'h00, (b & 1) ? model[b >> 1][15:8] : model[b >> 1][7:0]};
      check(rdData == expv, "R5 byte read", rdData, expv);
    end

    // R6: byte writes touch only their lane
    for (int b = 0; b < 64; b++) begin
      access(1'b1, 11'(b), {8'hEE, 8'(b * 7 + 3)}, "R6 byte write window");
      if (b & 1) model[b >> 1][15:8] = 8'(b * 7 + 3);
      else       model[b >> 1][7:0]  = 8'(b * 7 + 3);
    end
    wideMode = 1'b1;
    for (int i = 0; i < 32; i++) begin
      access(1'b0, 11'(i), 16'h0, "R2 read window");
      check(rdData == model[i], "R6 lane merge", rdData, model[i]);
    end

    // R3/R7: latch held across a non-matching write, updated by a matching one
    access(1'b0, 11'd100, 16'h0, "R2 read window");
    check(rdData == model[100], "R3 read", rdData, model[100]);
    access(1'b1, 11'd101, 16'hBEEF, "R6 write window");
    model[101] = 16'hBEEF;
    check(rdData == model[100], "R7 miss holds", rdData, model[100]);
    repeat (5) @(negedge clk);
    check(rdData == model[100], "R3 hold", rdData, model[100]);
    access(1'b1, 11'd100, 16'hC0DE, "R6 write window");
    model[100] = 16'hC0DE;
    check(rdData == 16'hC0DE, "R7 hit updates", rdData, 16'hC0DE);

    // R8: address change inside the window restarts it
    begin
      int n;
      sel = 1'b1; addr = 11'd200;
      @(negedge clk);
      addr = 11'd201;
      @(negedge clk);
      sel = 1'b0;
      n = 1;
      while (arrayEn && n < 20) begin n++; @(negedge clk); end
      check(n == ACT + 1, "R8 restart length", n, ACT + 1);
      check(rdData == model[201], "R8 latest data", rdData, model[201]);
    end

    // R11: select held on one address gives a single window
    begin
      int n;
      sel = 1'b1; addr = 11'd300;
      @(negedge clk);
      n = 0;
      while (arrayEn && n < 20) begin n++; @(negedge clk); end
      check(n == ACT, "R11 first window", n, ACT);
      check(rdData == model[300], "R11 data", rdData, model[300]);
      for (int k = 0; k < 4; k++) begin
        check(arrayEn == 1'b0, "R11 no rewake", arrayEn, 0);
        @(negedge clk);
      end
      sel = 1'b0;
      @(negedge clk);
    end

    // R9: write blocked during backup
    hold = rdData;
    backupHold = 1'b1; sel = 1'b1; wrEn = 1'b1; addr = 11'd400; wrData = 16'h1111;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(arrayEn == 1'b0, "R9 no wake", arrayEn, 0);
      check(rdData == hold, "R9 latch kept", rdData, hold);
    end
    sel = 1'b0; wrEn = 1'b0;
    @(negedge clk);
    backupHold = 1'b0;
    @(negedge clk);
    access(1'b0, 11'd400, 16'h0, "R2 read window");
    check(rdData == model[400], "R9 array kept", rdData, model[400]);

    // R9: backup aborts an open window without the read
    hold = rdData;
    sel = 1'b1; addr = 11'd401;
    @(negedge clk);
    check(arrayEn == 1'b1, "R9 window open", arrayEn, 1);
    backupHold = 1'b1; sel = 1'b0;
    @(negedge clk);
    check(arrayEn == 1'b0, "R9 abort", arrayEn, 0);
    repeat (3) @(negedge clk);
    backupHold = 1'b0;
    @(negedge clk);
    check(rdData == hold, "R9 abort no load", rdData, hold);
    check(arrayEn == 1'b0, "R9 stays idle", arrayEn, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #1500000;
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule